// File: doc/BRIEF.md
# Remote Terminal Command Response Arbiter

This block sits behind the word decoder of a MIL-STD-1553 remote terminal. For each command word it classifies the command through a fixed priority of exception cases. From that class it decides whether the terminal answers, whether data words follow the status word, and which status bits are raised. It also produces the side effects of the message: the descriptor update strobes, the message information word bits, the data-buffer commit and the interrupt requests.

The decoder presents the command word without its word-count field, together with a strobe and an error flag. The flag covers Manchester, parity and bit-count faults. The terminal supplies its own address with an odd parity bit, a broadcast-invalid configuration bit and an illegal-detection enable. A lookup of the illegalization table supplies one bit for the current command. The decisions are registered one cycle after the strobe and held until a one-cycle message-done pulse. Every descriptor, info-word, commit and interrupt effect is a single-cycle pulse in the cycle after that done pulse.

Top module: `rt_cmd_arbiter`

## Requirements
- R1: A command strobe with the word error flag set is ignored: no active message, no response, no status bit, no pulse, even when a later message-done arrives.
- R2: Commands to an address that is neither the own address nor 31 are ignored. Commands to the own address or 31 with subaddress 0 or 31 (mode codes) are also ignored. The command head layout is address in bits [10:6], transmit flag in bit 5 (1 = transmit) and subaddress in bits [4:0].
- R3: A valid command to address 31 is ignored without any side effect while broadcast-invalid is 1.
- R4: The own address is faulty when its five bits plus the parity bit hold an even number of ones. A command to the own address or to 31 is then ignored with no status change, and irqAddrParity pulses for exactly one cycle, the cycle after the strobe.
- R5: A transmit command to address 31 gets no response and no data, and sets the Message Error and Broadcast Command Received status bits. At completion it sets the descriptor accessed and broadcast bits, toggles ping-pong, sets the info message-error bit and raises the word-accessed interrupt, plus the broadcast interrupt when enabled.
- R6: A legal transmit command to the own address responds with a clear status word followed by data words.
- R7: When illegal detection is enabled and the table bit is 1, a transmit or receive command sends no data and sets Message Error. An own-address command still answers with the status word, and a broadcast command is not answered. At completion the info word carries both illegal and message-error bits, irqIllegal pulses, and no buffer commit, broadcast interrupt or index interrupt occurs.
- R8: A legal receive command to the own address responds with a clear status word and no data. The buffer commit pulses only after message-done.
- R9: At completion of every accepted message, the accessed and ping-pong strobes pulse together with infoWrite and irqWordAccess. For own-address messages the descriptor broadcast bit is cleared. The info word carries the bus and RT-to-RT flags captured at the strobe, with the other error bits clear on legal messages. irqIdxZero pulses on legal messages when both the index-zero flag and its enable are 1.
- R10: With illegal detection disabled the table bit has no effect and the command is answered normally.
- R11: Decisions stay constant from the cycle after the strobe until message-done, and strobes arriving during that time are ignored. Each completion pulse lasts exactly one cycle.
- R12: Case priority is word error, foreign address, broadcast disabled, address parity fault, mode code, broadcast transmit, illegal, normal.
- R13: A legal receive command to address 31 gets no response and sets Broadcast Command Received. At completion it sets the descriptor broadcast bit, commits the buffer and raises the broadcast interrupt when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdStrobe | input | 1 | Command word received |
| cmdErr | input | 1 | Manchester, parity or bit-count fault on that word |
| cmdHead | input | 11 | Command word less word count: address, transmit flag, subaddress |
| ownAddr | input | 5 | Terminal address |
| ownAddrPar | input | 1 | Odd parity bit of the terminal address |
| bcastInvalid | input | 1 | Treat broadcast commands as invalid |
| illegalEn | input | 1 | Illegal-command detection enable |
| illegalBit | input | 1 | Illegalization table bit for this command |
| busId | input | 1 | Bus on which the command arrived |
| rtRt | input | 1 | Command is part of an RT-to-RT transfer |
| idxZero | input | 1 | Descriptor index has reached zero |
| ieBcast | input | 1 | Enable broadcast-received interrupt |
| ieIdxZero | input | 1 | Enable index-zero interrupt |
| msgDone | input | 1 | Message complete pulse |
| msgActive | output | 1 | An accepted message is in progress |
| respond | output | 1 | Send a status word |
| sendData | output | 1 | Send data words after the status word |
| stMsgErr | output | 1 | Message Error status bit |
| stBcastRcvd | output | 1 | Broadcast Command Received status bit |
| descSetAccess | output | 1 | Pulse: set descriptor accessed bit |
| descToggle | output | 1 | Pulse: toggle descriptor ping-pong bit |
| descSetBcast | output | 1 | Pulse: set descriptor broadcast bit |
| descClrBcast | output | 1 | Pulse: clear descriptor broadcast bit |
| infoWrite | output | 1 | Pulse: write message info word |
| infoMsgErr | output | 1 | Info word message-error bit |
| infoIllegal | output | 1 | Info word illegal-command bit |
| infoBusId | output | 1 | Info word bus identifier |
| infoRtRt | output | 1 | Info word RT-to-RT flag |
| bufCommit | output | 1 | Pulse: commit received data to buffer |
| irqAddrParity | output | 1 | Address parity fault interrupt |
| irqWordAccess | output | 1 | Word-accessed interrupt |
| irqBcastRcvd | output | 1 | Broadcast-received interrupt |
| irqIdxZero | output | 1 | Index-equals-zero interrupt |
| irqIllegal | output | 1 | Illegal-command interrupt |

## Verification
The bench builds the block with its default widths: 5-bit addresses and subaddresses and own address 5. This puts the broadcast address 31 and both mode-code subaddresses (0 and 31) within direct reach of a small table. One own-address parity bit value makes the address valid and the other makes it faulty, so every priority crossing can be set up in one vector. That includes parity fault under broadcast-disabled, error under broadcast, and broadcast transmit under the illegal bit.

// File: rtl/rt_arb_pkg.sv
package rt_arb_pkg;

  typedef enum logic [2:0] {
    CLS_DROP,
    CLS_FOREIGN,
    CLS_BC_OFF,
    CLS_PAR_FAULT,
    CLS_MODE,
    CLS_BC_TX,
    CLS_ILLEGAL,
    CLS_NORMAL
  } cmd_class_e;

  typedef struct packed {
    logic load;
    logic finish;
    logic parPulse;
    logic bcast;
    logic tx;
    logic illegal;
    logic bcTx;
  } ctrl_strobe_t;

endpackage

// File: rtl/rt_resp_ctrl.sv
module rt_resp_ctrl
  import rt_arb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SA_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmdStrobe,
  input  logic                     cmdErr,
  input  logic [ADDR_W+SA_W:0]     cmdHead,
  input  logic [ADDR_W-1:0]        ownAddr,
  input  logic                     ownAddrPar,
  input  logic                     bcastInvalid,
  input  logic                     illegalEn,
  input  logic                     illegalBit,
  input  logic                     msgDone,
  output ctrl_strobe_t             strobe,
  output logic                     busy
);

  localparam int HEAD_W = ADDR_W + SA_W + 1;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [SA_W-1:0]   SA_MODE_LO = '0;
  localparam logic [SA_W-1:0]   SA_MODE_HI = {SA_W{1'b1}};

  logic [ADDR_W-1:0] cmdAddr;
  logic [SA_W-1:0]   cmdSa;
  logic              cmdTx;
  logic              toOwn;
  logic              toBcast;
  logic              addrParOk;
  logic              accept;
  cmd_class_e        cls;

  assign cmdAddr   = cmdHead[HEAD_W-1 -: ADDR_W];
  assign cmdTx     = cmdHead[SA_W];
  assign cmdSa     = cmdHead[SA_W-1:0];
  assign toBcast   = (cmdAddr == BCAST_ADDR);
  assign toOwn     = (cmdAddr == ownAddr) && !toBcast;
  assign addrParOk = ^{ownAddr, ownAddrPar};

  always_comb begin
    if (cmdErr)                                  cls = CLS_DROP;
    else if (!toOwn && !toBcast)                 cls = CLS_FOREIGN;
    else if (toBcast && bcastInvalid)            cls = CLS_BC_OFF;
    else if (!addrParOk)                         cls = CLS_PAR_FAULT;
    else if (cmdSa == SA_MODE_LO || cmdSa == SA_MODE_HI) cls = CLS_MODE;
    else if (toBcast && cmdTx)                   cls = CLS_BC_TX;
    else if (illegalEn && illegalBit)            cls = CLS_ILLEGAL;
    else                                         cls = CLS_NORMAL;
  end

  assign accept = cmdStrobe && !busy;

  always_comb begin
    strobe.load     = accept && (cls == CLS_BC_TX || cls == CLS_ILLEGAL || cls == CLS_NORMAL);
    strobe.parPulse = accept && (cls == CLS_PAR_FAULT);
    strobe.finish   = busy && msgDone;
    strobe.bcast    = toBcast;
    strobe.tx       = cmdTx;
    strobe.illegal  = (cls == CLS_ILLEGAL);
    strobe.bcTx     = (cls == CLS_BC_TX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             busy <= 1'b0;
    else if (strobe.load)   busy <= 1'b1;
    else if (strobe.finish) busy <= 1'b0;
  end

  // R1: an errored word never opens a message
  assert_drop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStrobe && cmdErr && !busy) |=> !busy);

  // R11: a message stays open until done
  assert_hold_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !msgDone) |=> busy);

  // R11: done closes the message
  assert_done_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && msgDone) |=> !busy);

  // R4: parity fault never opens a message
  assert_par_no_msg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.parPulse |=> !busy);

endmodule

// File: rtl/rt_resp_dp.sv
module rt_resp_dp
  import rt_arb_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_strobe_t strobe,
  input  logic         busId,
  input  logic         rtRt,
  input  logic         idxZero,
  input  logic         ieBcast,
  input  logic         ieIdxZero,
  output logic         respond,
  output logic         sendData,
  output logic         stMsgErr,
  output logic         stBcastRcvd,
  output logic         descSetAccess,
  output logic         descToggle,
  output logic         descSetBcast,
  output logic         descClrBcast,
  output logic         infoWrite,
  output logic         infoMsgErr,
  output logic         infoIllegal,
  output logic         infoBusId,
  output logic         infoRtRt,
  output logic         bufCommit,
  output logic         irqAddrParity,
  output logic         irqWordAccess,
  output logic         irqBcastRcvd,
  output logic         irqIdxZero,
  output logic         irqIllegal
);

  logic illHeld, rxHeld, busHeld, rtHeld;
  logic fin;

  assign fin = strobe.finish;

  // held decisions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respond     <= 1'b0;
      sendData    <= 1'b0;
      stMsgErr    <= 1'b0;
      stBcastRcvd <= 1'b0;
      illHeld     <= 1'b0;
      rxHeld      <= 1'b0;
      busHeld     <= 1'b0;
      rtHeld      <= 1'b0;
    end else if (strobe.load) begin
      respond     <= !strobe.bcast;
      sendData    <= !strobe.bcast && strobe.tx && !strobe.illegal;
      stMsgErr    <= strobe.illegal || strobe.bcTx;
      stBcastRcvd <= strobe.bcast;
      illHeld     <= strobe.illegal;
      rxHeld      <= !strobe.tx;
      busHeld     <= busId;
      rtHeld      <= rtRt;
    end else if (fin) begin
      respond     <= 1'b0;
      sendData    <= 1'b0;
      stMsgErr    <= 1'b0;
      stBcastRcvd <= 1'b0;
      illHeld     <= 1'b0;
      rxHeld      <= 1'b0;
      busHeld     <= 1'b0;
      rtHeld      <= 1'b0;
    end
  end

  // completion pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      descSetAccess <= 1'b0;
      descToggle    <= 1'b0;
      descSetBcast  <= 1'b0;
      descClrBcast  <= 1'b0;
      infoWrite     <= 1'b0;
      infoMsgErr    <= 1'b0;
      infoIllegal   <= 1'b0;
      infoBusId     <= 1'b0;
      infoRtRt      <= 1'b0;
      bufCommit     <= 1'b0;
      irqAddrParity <= 1'b0;
      irqWordAccess <= 1'b0;
      irqBcastRcvd  <= 1'b0;
      irqIdxZero    <= 1'b0;
      irqIllegal    <= 1'b0;
    end else begin
      descSetAccess <= fin;
      descToggle    <= fin;
      descSetBcast  <= fin && stBcastRcvd;
      descClrBcast  <= fin && !stBcastRcvd;
      infoWrite     <= fin;
      infoMsgErr    <= fin && stMsgErr;
      infoIllegal   <= fin && illHeld;
      infoBusId     <= fin && busHeld;
      infoRtRt      <= fin && rtHeld;
      bufCommit     <= fin && rxHeld && !illHeld;
      irqAddrParity <= strobe.parPulse;
      irqWordAccess <= fin;
      irqBcastRcvd  <= fin && stBcastRcvd && !illHeld && ieBcast;
      irqIdxZero    <= fin && !illHeld && ieIdxZero && idxZero;
      irqIllegal    <= fin && illHeld;
    end
  end

  // R6: data only follows a status word
  assert_data_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sendData |-> respond);

  // R7: illegal always carries message error in the info word
  assert_ilcmd_has_merr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    infoIllegal |-> infoMsgErr);

  // R5: broadcast is never answered
  assert_bcast_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stBcastRcvd |-> !respond);

  // R11: one toggle per message
  assert_toggle_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    descToggle |=> !descToggle);

  // R4: parity fault interrupt comes with no response
  assert_par_no_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irqAddrParity |-> (!respond && !stMsgErr));

  // R9: broadcast set and clear are exclusive
  assert_bcast_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(descSetBcast && descClrBcast));

endmodule

// File: rtl/rt_cmd_arbiter.sv
module rt_cmd_arbiter
  import rt_arb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SA_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdStrobe,
  input  logic                 cmdErr,
  input  logic [ADDR_W+SA_W:0] cmdHead,
  input  logic [ADDR_W-1:0]    ownAddr,
  input  logic                 ownAddrPar,
  input  logic                 bcastInvalid,
  input  logic                 illegalEn,
  input  logic                 illegalBit,
  input  logic                 busId,
  input  logic                 rtRt,
  input  logic                 idxZero,
  input  logic                 ieBcast,
  input  logic                 ieIdxZero,
  input  logic                 msgDone,
  output logic                 msgActive,
  output logic                 respond,
  output logic                 sendData,
  output logic                 stMsgErr,
  output logic                 stBcastRcvd,
  output logic                 descSetAccess,
  output logic                 descToggle,
  output logic                 descSetBcast,
  output logic                 descClrBcast,
  output logic                 infoWrite,
  output logic                 infoMsgErr,
  output logic                 infoIllegal,
  output logic                 infoBusId,
  output logic                 infoRtRt,
  output logic                 bufCommit,
  output logic                 irqAddrParity,
  output logic                 irqWordAccess,
  output logic                 irqBcastRcvd,
  output logic                 irqIdxZero,
  output logic                 irqIllegal
);

  ctrl_strobe_t strobe;

  rt_resp_ctrl #(.ADDR_W(ADDR_W), .SA_W(SA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdStrobe(cmdStrobe), .cmdErr(cmdErr), .cmdHead(cmdHead),
    .ownAddr(ownAddr), .ownAddrPar(ownAddrPar),
    .bcastInvalid(bcastInvalid), .illegalEn(illegalEn), .illegalBit(illegalBit),
    .msgDone(msgDone), .strobe(strobe), .busy(msgActive)
  );

  rt_resp_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .busId(busId), .rtRt(rtRt), .idxZero(idxZero),
    .ieBcast(ieBcast), .ieIdxZero(ieIdxZero),
    .respond(respond), .sendData(sendData),
    .stMsgErr(stMsgErr), .stBcastRcvd(stBcastRcvd),
    .descSetAccess(descSetAccess), .descToggle(descToggle),
    .descSetBcast(descSetBcast), .descClrBcast(descClrBcast),
    .infoWrite(infoWrite), .infoMsgErr(infoMsgErr), .infoIllegal(infoIllegal),
    .infoBusId(infoBusId), .infoRtRt(infoRtRt), .bufCommit(bufCommit),
    .irqAddrParity(irqAddrParity), .irqWordAccess(irqWordAccess),
    .irqBcastRcvd(irqBcastRcvd), .irqIdxZero(irqIdxZero), .irqIllegal(irqIllegal)
  );

endmodule

// File: tb/sim_rt_cmd_arbiter.sv
`timescale 1ns/1ps
module sim_rt_cmd_arbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdStrobe = 0, cmdErr = 0;
  logic [10:0] cmdHead = '0;
  logic [4:0] ownAddr = 5'd5;
  logic ownAddrPar = 1'b1;
  logic bcastInvalid = 0, illegalEn = 0, illegalBit = 0;
  logic busId = 0, rtRt = 0, idxZero = 1, ieBcast = 1, ieIdxZero = 1;
  logic msgDone = 0;
  logic msgActive, respond, sendData, stMsgErr, stBcastRcvd;
  logic descSetAccess, descToggle, descSetBcast, descClrBcast;
  logic infoWrite, infoMsgErr, infoIllegal, infoBusId, infoRtRt, bufCommit;
  logic irqAddrParity, irqWordAccess, irqBcastRcvd, irqIdxZero, irqIllegal;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rt_cmd_arbiter u0 (.*);

  // {err, addr[5], tx, sa[5], parBad, bcInv, ilEn, ilBit,
  //  expActive, expResp, expSend, expME, expBCR, expPar, expCommit, expIll}
  localparam int NV = 18;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 5'd5,  1'b1, 5'd3,  4'b0000, 8'b0000_0000},
    {1'b0, 5'd7,  1'b1, 5'd3,  4'b0000, 8'b0000_0000},
    {1'b0, 5'd5,  1'b1, 5'd0,  4'b0000, 8'b0000_0000},
    {1'b0, 5'd31, 1'b0, 5'd4,  4'b0100, 8'b0000_0000},
    {1'b0, 5'd5,  1'b1, 5'd3,  4'b1000, 8'b0000_0100},
    {1'b0, 5'd31, 1'b0, 5'd3,  4'b1100, 8'b0000_0000},
    {1'b0, 5'd7,  1'b0, 5'd3,  4'b1000, 8'b0000_0000},
    {1'b0, 5'd31, 1'b1, 5'd3,  4'b0000, 8'b1001_1000},
    {1'b0, 5'd5,  1'b1, 5'd3,  4'b0000, 8'b1110_0000},
    {1'b0, 5'd5,  1'b1, 5'd9,  4'b0011, 8'b1101_0001},
    {1'b0, 5'd5,  1'b0, 5'd2,  4'b0000, 8'b1100_0010},
    {1'b0, 5'd5,  1'b0, 5'd2,  4'b0011, 8'b1101_0001},
    {1'b0, 5'd31, 1'b0, 5'd6,  4'b0000, 8'b1000_1010},
    {1'b0, 5'd5,  1'b1, 5'd3,  4'b0001, 8'b1110_0000},
    {1'b1, 5'd31, 1'b0, 5'd6,  4'b0000, 8'b0000_0000},
    {1'b0, 5'd31, 1'b0, 5'd6,  4'b0011, 8'b1001_1001},
    {1'b0, 5'd31, 1'b1, 5'd3,  4'b0011, 8'b1001_1000},
    {1'b0, 5'd5,  1'b0, 5'd31, 4'b0000, 8'b0000_0000}
  };

  function automatic string vecTag(input int i);
    case (i)
      0: return "R1";  1, 2, 6, 17: return "R2";  3: return "R3";
      4: return "R4";  5, 14, 16: return "R12";   7: return "R5";
      8: return "R6";  9, 11, 15: return "R7";    10: return "R8";
      12: return "R13"; default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic sendCmd(input logic err, input logic [4:0] addr, input logic tx,
                         input logic [4:0] sa);
    cmdErr = err;
    cmdHead = {addr, tx, sa};
    cmdStrobe = 1'b1;
    @(negedge clk);
    cmdStrobe = 1'b0;
  endtask

  task automatic pulseDone();
    msgDone = 1'b1;
    @(negedge clk);
    msgDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R11", "reset msgActive", msgActive, 0);
    check("R11", "reset respond", respond, 0);
    check("R9", "reset descToggle", descToggle, 0);
    check("R4", "reset irqAddrParity", irqAddrParity, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string t;
      logic act, me, bcr, ill;
      v = VEC[i];
      t = vecTag(i);
      act = v[7]; me = v[4]; bcr = v[3]; ill = v[0];
      ownAddrPar = v[11] ? 1'b0 : 1'b1;
      bcastInvalid = v[10];
      illegalEn = v[9];
      illegalBit = v[8];
      busId = i[0];
      rtRt = i[1];
      sendCmd(v[23], v[22:18], v[17], v[16:12]);
      check(t, $sformatf("v%0d msgActive", i), msgActive, act);
      check(t, $sformatf("v%0d respond", i), respond, v[6]);
      check(t, $sformatf("v%0d sendData", i), sendData, v[5]);
      check(t, $sformatf("v%0d stMsgErr", i), stMsgErr, me);
      check(t, $sformatf("v%0d stBcastRcvd", i), stBcastRcvd, bcr);
      check(t, $sformatf("v%0d irqAddrParity", i), irqAddrParity, v[2]);
      @(negedge clk);
      check("R11", $sformatf("v%0d held msgActive", i), msgActive, act);
      check("R11", $sformatf("v%0d held stMsgErr", i), stMsgErr, me);
      check("R4", $sformatf("v%0d parity pulse ends", i), irqAddrParity, 0);
      pulseDone();
      check("R9", $sformatf("v%0d descToggle", i), descToggle, act);
      check("R9", $sformatf("v%0d descSetAccess", i), descSetAccess, act);
      check("R9", $sformatf("v%0d infoWrite", i), infoWrite, act);
      check("R9", $sformatf("v%0d irqWordAccess", i), irqWordAccess, act);
      check(t, $sformatf("v%0d descSetBcast", i), descSetBcast, act && bcr);
      check("R9", $sformatf("v%0d descClrBcast", i), descClrBcast, act && !bcr);
      check(t, $sformatf("v%0d infoMsgErr", i), infoMsgErr, me);
      check(t, $sformatf("v%0d infoIllegal", i), infoIllegal, ill);
      check(t, $sformatf("v%0d bufCommit", i), bufCommit, v[1]);
      check(t, $sformatf("v%0d irqIllegal", i), irqIllegal, ill);
      check(t, $sformatf("v%0d irqBcastRcvd", i), irqBcastRcvd, act && bcr && !ill);
      check("R9", $sformatf("v%0d irqIdxZero", i), irqIdxZero, act && !ill);
      check("R9", $sformatf("v%0d infoBusId", i), infoBusId, act && i[0]);
      check("R9", $sformatf("v%0d infoRtRt", i), infoRtRt, act && i[1]);
      @(negedge clk);
      check("R11", $sformatf("v%0d toggle one cycle", i), descToggle, 0);
      check("R11", $sformatf("v%0d closed", i), msgActive, 0);
    end

    // R11: strobes during an open message are ignored
    ownAddrPar = 1'b1; bcastInvalid = 0; illegalEn = 0; illegalBit = 0;
    sendCmd(1'b0, 5'd5, 1'b1, 5'd3);
    sendCmd(1'b0, 5'd31, 1'b0, 5'd4);
    check("R11", "busy ignores respond", respond, 1);
    check("R11", "busy ignores sendData", sendData, 1);
    check("R11", "busy ignores stBcastRcvd", stBcastRcvd, 0);
    repeat (5) @(negedge clk);
    check("R11", "still held sendData", sendData, 1);
    pulseDone();
    check("R11", "first message completes", descClrBcast, 1);
    check("R11", "no commit from ignored rx", bufCommit, 0);
    @(negedge clk);

    // R9 / R13: optional interrupts off
    ieBcast = 0; idxZero = 0; ieIdxZero = 1;
    sendCmd(1'b0, 5'd31, 1'b0, 5'd6);
    pulseDone();
    check("R13", "ibr disabled", irqBcastRcvd, 0);
    check("R13", "commit still", bufCommit, 1);
    check("R9", "index flag clear", irqIdxZero, 0);
    @(negedge clk);
    idxZero = 1; ieIdxZero = 0;
    sendCmd(1'b0, 5'd5, 1'b0, 5'd6);
    pulseDone();
    check("R9", "index irq disabled", irqIdxZero, 0);
    check("R8", "own rx commit", bufCommit, 1);
    @(negedge clk);

    // R10: detection off, table bit set, receive
    illegalEn = 0; illegalBit = 1;
    sendCmd(1'b0, 5'd5, 1'b0, 5'd6);
    check("R10", "rx answered", respond, 1);
    check("R10", "no ME", stMsgErr, 0);
    pulseDone();
    check("R10", "no illegal irq", irqIllegal, 0);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule